// File: doc/BRIEF.md
# Alternating Step Keystream Generator

This block turns a weak, possibly biased stream of control bits into a keystream of one bit per clock. It holds two long linear feedback shift registers of different lengths, 127 and 129 bits, each built on a dense primitive polynomial with many feedback taps. On every enabled clock exactly one of the two registers advances, and the control bit picks which one. The keystream bit is the exclusive-or of the top stages of the two registers.

In a system the control bit comes from a sampled noise source outside this block. For deterministic checking, a parameter can swap in a small internal 8-bit control register instead, and the external control pin is then ignored. A seed load writes both long registers at once. An all-zero seed is never accepted as is; it is replaced by a fixed nonzero value.

Top module: `asg_keygen`

## Requirements
- R1: After reset register A holds 1, register B holds 1, `key_valid` is 0 and `key_bit` is 0.
- R2: On an enabled cycle without seed load, a control bit of 1 shifts register A once toward its top stage and leaves register B unchanged.
- R3: On an enabled cycle without seed load, a control bit of 0 shifts register B once and leaves register A unchanged.
- R4: `key_bit` always equals the exclusive-or of bit 126 of register A and bit 128 of register B.
- R5: Register A shifts left and takes into bit 0 the parity of its bits 126, 101, 60 and 58 down to 0, matching x^127 + x^102 + x^61 + x^59 + ... + x + 1.
- R6: Register B shifts left and takes into bit 0 the parity of its bits 128, 118 and 61 down to 0, matching x^129 + x^119 + x^62 + ... + x + 1.
- R7: A seed load writes `seed_a` into A and `seed_b` into B; a seed of all zeros is replaced by the value 1, each register on its own. Seed load takes priority over enable, and both registers stay nonzero at all times.
- R8: With `enable` low and no seed load, both registers hold and `key_bit` does not change, whatever `ctrl_in` does.
- R9: `key_valid` is 1 in the cycle after an enabled cycle without seed load and 0 after any other cycle.
- R10: With the internal control source selected, the control bit is bit 7 of an 8-bit register that starts (at reset and at every seed load) at 8'hA5, shifts left on each enabled cycle without seed load taking the parity of bits 7, 5, 4 and 3, and `ctrl_in` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| seed_load | input | 1 | Load both registers from the seed inputs |
| seed_a | input | 127 | Seed for register A |
| seed_b | input | 129 | Seed for register B |
| enable | input | 1 | Advance one register this cycle |
| ctrl_in | input | 1 | External control bit: 1 steps A, 0 steps B |
| key_bit | output | 1 | Keystream bit |
| key_valid | output | 1 | Key bit produced by an enabled step |

## Verification
The bench drives the external-control instance with a control stream that alternates, one that stays high for more than a full register length, one that stays low likewise, and a pseudo-random stream; steady runs expose a wrong feedback polynomial in one register alone, while alternation exposes a swapped selection. Idle stretches with a toggling control pin separate holding from stepping, and seed loads of zero and nonzero values, including loads with enable high, separate substitution from plain loading and load priority from stepping. A second instance with the internal control source runs the same enable pattern under a toggling `ctrl_in` and must follow a model driven only by the internal register.

// File: rtl/asg_pkg.sv
package asg_pkg;

   localparam int MAXW = 256;

   // Builds a Fibonacci tap mask: top term, two optional middle terms and
   // a contiguous run of low terms x^run .. x^1 (bit k-1 for term x^k).
   function automatic logic [MAXW-1:0] poly_mask(input int len, input int mid1,
                                                 input int mid2, input int run);
      logic [MAXW-1:0] m;
      m = '0;
      m[len-1] = 1'b1;
      if (mid1 > 0) m[mid1-1] = 1'b1;
      if (mid2 > 0) m[mid2-1] = 1'b1;
      for (int k = 0; k < run; k++) m[k] = 1'b1;
      return m;
   endfunction

   typedef enum logic {CTRL_EXTERNAL = 1'b0, CTRL_INTERNAL = 1'b1} ctrl_src_e;

endpackage

// File: rtl/asg_lfsr.sv
module asg_lfsr #(
   parameter int            W    = 8,
   parameter logic [W-1:0]  TAPS = '0,
   parameter logic [W-1:0]  FILL = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [W-1:0]  seed,
   input  logic          step,
   output logic [W-1:0]  state
);

   localparam int NTAPS = $countones(TAPS);

   if (W < 2) begin : g_bad_w
      $error("asg_lfsr: width must be at least 2");
   end
   if (TAPS[W-1] != 1'b1) begin : g_bad_top
      $error("asg_lfsr: top tap must be set");
   end
   if (FILL == '0) begin : g_bad_fill
      $error("asg_lfsr: fill value must be nonzero");
   end
   if (NTAPS < 2) begin : g_bad_taps
      $error("asg_lfsr: at least two taps needed");
   end

   logic          fb;
   logic [W-1:0]  seed_fix;
   logic [W-1:0]  state_nx;

   assign fb       = ^(state & TAPS);
   assign seed_fix = (seed == '0) ? FILL : seed;

   always_comb begin
      state_nx = state;
      if (load)      state_nx = seed_fix;
      else if (step) state_nx = {state[W-2:0], fb};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= FILL;
      else        state <= state_nx;
   end

endmodule

// File: rtl/asg_ctrl_src.sv
module asg_ctrl_src #(
   parameter asg_pkg::ctrl_src_e SRC   = asg_pkg::CTRL_EXTERNAL,
   parameter int                 CW    = 8,
   parameter logic [CW-1:0]      CTAPS = 8'hB8,
   parameter logic [CW-1:0]      CSEED = 8'hA5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic enable,
   input  logic ext_bit,
   output logic sel
);

   if (SRC == asg_pkg::CTRL_INTERNAL) begin : g_internal
      logic [CW-1:0] cstate;
      logic          unused_ext;

      asg_lfsr #(.W(CW), .TAPS(CTAPS), .FILL(CSEED)) ctrl_lfsr_i (
         .clk   (clk),
         .rst_n (rst_n),
         .load  (load),
         .seed  (CSEED),
         .step  (enable & ~load),
         .state (cstate)
      );

      assign sel        = cstate[CW-1];
      assign unused_ext = ext_bit;
   end else begin : g_external
      logic unused_ctl;
      assign sel        = ext_bit;
      assign unused_ctl = ^{clk, rst_n, load, enable};
   end

endmodule

// File: rtl/asg_keygen.sv
module asg_keygen #(
   parameter int                 A_LEN  = 127,
   parameter int                 A_MID1 = 102,
   parameter int                 A_MID2 = 61,
   parameter int                 A_RUN  = 59,
   parameter int                 B_LEN  = 129,
   parameter int                 B_MID1 = 119,
   parameter int                 B_MID2 = 0,
   parameter int                 B_RUN  = 62,
   parameter asg_pkg::ctrl_src_e CTRL_SRC  = asg_pkg::CTRL_EXTERNAL,
   parameter int                 CTRL_W    = 8,
   parameter logic [CTRL_W-1:0]  CTRL_TAPS = 8'hB8,
   parameter logic [CTRL_W-1:0]  CTRL_SEED = 8'hA5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             seed_load,
   input  logic [A_LEN-1:0] seed_a,
   input  logic [B_LEN-1:0] seed_b,
   input  logic             enable,
   input  logic             ctrl_in,
   output logic             key_bit,
   output logic             key_valid
);

   localparam logic [asg_pkg::MAXW-1:0] A_MASK_W =
      asg_pkg::poly_mask(A_LEN, A_MID1, A_MID2, A_RUN);
   localparam logic [asg_pkg::MAXW-1:0] B_MASK_W =
      asg_pkg::poly_mask(B_LEN, B_MID1, B_MID2, B_RUN);
   localparam logic [A_LEN-1:0] A_TAPS = A_MASK_W[A_LEN-1:0];
   localparam logic [B_LEN-1:0] B_TAPS = B_MASK_W[B_LEN-1:0];
   localparam logic [A_LEN-1:0] A_FILL = 1;
   localparam logic [B_LEN-1:0] B_FILL = 1;

   if (A_LEN > asg_pkg::MAXW || B_LEN > asg_pkg::MAXW) begin : g_bad_len
      $error("asg_keygen: register length exceeds package limit");
   end
   if (A_LEN == B_LEN) begin : g_same_len
      $error("asg_keygen: register lengths must differ");
   end
   if (A_MID1 >= A_LEN || A_MID2 >= A_LEN || A_RUN >= A_LEN) begin : g_bad_a
      $error("asg_keygen: register A tap out of range");
   end
   if (B_MID1 >= B_LEN || B_MID2 >= B_LEN || B_RUN >= B_LEN) begin : g_bad_b
      $error("asg_keygen: register B tap out of range");
   end

   logic             step_sel;
   logic             step_ok;
   logic [A_LEN-1:0] a_state;
   logic [B_LEN-1:0] b_state;

   assign step_ok = enable & ~seed_load;

   asg_ctrl_src #(
      .SRC   (CTRL_SRC),
      .CW    (CTRL_W),
      .CTAPS (CTRL_TAPS),
      .CSEED (CTRL_SEED)
   ) ctrl_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (seed_load),
      .enable  (enable),
      .ext_bit (ctrl_in),
      .sel     (step_sel)
   );

   asg_lfsr #(.W(A_LEN), .TAPS(A_TAPS), .FILL(A_FILL)) reg_a_i (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (seed_load),
      .seed  (seed_a),
      .step  (step_ok & step_sel),
      .state (a_state)
   );

   asg_lfsr #(.W(B_LEN), .TAPS(B_TAPS), .FILL(B_FILL)) reg_b_i (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (seed_load),
      .seed  (seed_b),
      .step  (step_ok & ~step_sel),
      .state (b_state)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) key_valid <= 1'b0;
      else        key_valid <= step_ok;
   end

   assign key_bit = a_state[A_LEN-1] ^ b_state[B_LEN-1];

endmodule

// File: rtl/asg_keygen_chk.sv
module asg_keygen_chk #(
   parameter int A_LEN = 127,
   parameter int B_LEN = 129
) (
   input logic             clk,
   input logic             rst_n,
   input logic             seed_load,
   input logic             enable,
   input logic             sel,
   input logic [A_LEN-1:0] a_q,
   input logic [B_LEN-1:0] b_q,
   input logic             key_valid
);

   p_valid_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !seed_load) |=> key_valid);

   p_valid_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable || seed_load) |=> !key_valid);

   p_a_steps_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !seed_load && sel) |=>
         ($stable(b_q) && a_q[A_LEN-1:1] == $past(a_q[A_LEN-2:0])));

   p_b_steps_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !seed_load && !sel) |=>
         ($stable(a_q) && b_q[B_LEN-1:1] == $past(b_q[B_LEN-2:0])));

   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && !seed_load) |=> ($stable(a_q) && $stable(b_q)));

   p_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (a_q != '0) && (b_q != '0));

endmodule

bind asg_keygen asg_keygen_chk #(.A_LEN(A_LEN), .B_LEN(B_LEN)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .seed_load (seed_load),
   .enable    (enable),
   .sel       (step_sel),
   .a_q       (a_state),
   .b_q       (b_state),
   .key_valid (key_valid)
);

// File: tb/asg_keygen_tb_top.sv
`timescale 1ns/1ps
module asg_keygen_tb_top;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         seed_load = 1'b0;
   logic [126:0] seed_a = '0;
   logic [128:0] seed_b = '0;
   logic         enable = 1'b0;
   logic         ctrl_in = 1'b0;
   logic         key_bit, key_valid;
   logic         ikey_bit, ikey_valid;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   asg_keygen dut_i (
      .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_a(seed_a),
      .seed_b(seed_b), .enable(enable), .ctrl_in(ctrl_in),
      .key_bit(key_bit), .key_valid(key_valid)
   );

   asg_keygen #(.CTRL_SRC(asg_pkg::CTRL_INTERNAL)) dut_int_i (
      .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_a(seed_a),
      .seed_b(seed_b), .enable(enable), .ctrl_in(ctrl_in),
      .key_bit(ikey_bit), .key_valid(ikey_valid)
   );

   localparam logic [127:0] SA_W = {4{32'hC3A5_96E1}};
   localparam logic [159:0] SB_W = {5{32'h5A3C_E187}};
   localparam logic [126:0] SA = SA_W[126:0];
   localparam logic [128:0] SB = SB_W[128:0];

   // {seed_load, enable, ctrl_in, expected key_valid}
   localparam int NV = 20;
   localparam logic [3:0] VEC [NV] = '{
      4'b1100, 4'b0111, 4'b0101, 4'b0111, 4'b0101,
      4'b0010, 4'b0000, 4'b0111, 4'b0111, 4'b0101,
      4'b1010, 4'b0101, 4'b0101, 4'b0111, 4'b0000,
      4'b1110, 4'b0111, 4'b0010, 4'b0101, 4'b0111
   };

   // independent reference models
   logic [126:0] ma, ia;
   logic [128:0] mb, ib;
   logic [7:0]   ics;

   function automatic logic fba(input logic [126:0] s);
      return s[126] ^ s[101] ^ s[60] ^ (^s[58:0]);
   endfunction
   function automatic logic fbb(input logic [128:0] s);
      return s[128] ^ s[118] ^ (^s[61:0]);
   endfunction

   task automatic model_reset();
      ma = 127'd1; mb = 129'd1; ia = 127'd1; ib = 129'd1; ics = 8'hA5;
   endtask

   task automatic model_step(input logic ld, input logic en, input logic c);
      logic isel;
      if (ld) begin
         ma = (seed_a == '0) ? 127'd1 : seed_a;
         mb = (seed_b == '0) ? 129'd1 : seed_b;
         ia = ma; ib = mb; ics = 8'hA5;
      end else if (en) begin
         if (c) ma = {ma[125:0], fba(ma)};
         else   mb = {mb[127:0], fbb(mb)};
         isel = ics[7];
         ics  = {ics[6:0], ics[7] ^ ics[5] ^ ics[4] ^ ics[3]};
         if (isel) ia = {ia[125:0], fba(ia)};
         else      ib = {ib[127:0], fbb(ib)};
      end
   endtask

   task automatic check(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
      end
   endtask

   // one clock: drive at negedge, model at posedge, check at next negedge
   task automatic step(input logic ld, input logic en, input logic c,
                       input logic exp_valid, input string tag);
      seed_load = ld; enable = en; ctrl_in = c;
      @(posedge clk);
      model_step(ld, en, c);
      @(negedge clk);
      check({tag, " key"}, key_bit, ma[126] ^ mb[128]);
      check({tag, " valid R9"}, key_valid, exp_valid);
      check({tag, " internal key R10"}, ikey_bit, ia[126] ^ ib[128]);
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [15:0] pr;
      logic        kb;
      model_reset();
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 key", key_bit, 1'b0);
      check("R1 valid", key_valid, 1'b0);
      check("R1 internal key", ikey_bit, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      // vector table walk (R2, R3, R4, R7, R8, R9)
      seed_a = SA; seed_b = SB;
      for (int i = 0; i < NV; i++)
         step(VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0], "R4 table");

      // R2 / R5: long run stepping only A
      for (int i = 0; i < 300; i++) step(1'b0, 1'b1, 1'b1, 1'b1, "R2 R5 run-A");
      // R3 / R6: long run stepping only B
      for (int i = 0; i < 300; i++) step(1'b0, 1'b1, 1'b0, 1'b1, "R3 R6 run-B");
      // alternating control
      for (int i = 0; i < 300; i++) step(1'b0, 1'b1, i[0], 1'b1, "R2 R3 alternate");

      // R8: idle with toggling control, key must hold
      kb = key_bit;
      for (int i = 0; i < 10; i++) begin
         step(1'b0, 1'b0, i[0], 1'b0, "R8 idle");
         check("R8 key stable", key_bit, kb);
      end

      // R7: zero seed for A only, then zero seed for B only
      seed_a = '0; seed_b = SB;
      step(1'b1, 1'b1, 1'b1, 1'b0, "R7 zero A load");
      for (int i = 0; i < 200; i++) step(1'b0, 1'b1, 1'b1, 1'b1, "R7 zero A run");
      seed_a = SA; seed_b = '0;
      step(1'b1, 1'b0, 1'b0, 1'b0, "R7 zero B load");
      for (int i = 0; i < 200; i++) step(1'b0, 1'b1, 1'b0, 1'b1, "R7 zero B run");

      // pseudo-random control and enable, ctrl_in also noise for R10
      seed_a = SA; seed_b = SB;
      step(1'b1, 1'b0, 1'b0, 1'b0, "R7 reload");
      pr = 16'hACE1;
      for (int i = 0; i < 1200; i++) begin
         pr = {pr[14:0], pr[15] ^ pr[13] ^ pr[12] ^ pr[10]};
         step(1'b0, pr[3] | pr[7], pr[0], pr[3] | pr[7], "R10 random");
      end

      // R1: asynchronous reset mid-run returns to reset state
      rst_n = 1'b0;
      #1;
      model_reset();
      @(negedge clk);
      check("R1 reset key", key_bit, 1'b0);
      check("R1 reset valid", key_valid, 1'b0);
      rst_n = 1'b1;
      for (int i = 0; i < 300; i++) step(1'b0, 1'b1, i[1], 1'b1, "R4 after reset");

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule